// File: doc/BRIEF.md
# Pipelined Linear Congruential Noise Sample Generator

This block produces a stream of pseudo-random sample words from a 32-bit linear congruential recurrence. It is meant for a fast clock. The modular multiply is cut into registered partial products, those are summed in their own register stage, and the additive constant is applied in a third stage. For each request, one state update therefore takes a fixed number of cycles.

A client pulses a request strobe whenever it wants a new sample, for example from a divided-down sample-rate tick. Some cycles later the block commits the new state. In that same cycle it presents a sample word taken from the top bits of the state that was held before the commit, and it pulses a one-cycle valid. While an update is in flight, a busy output is high and further requests are dropped. A seed can be written into the state at any time through a load strobe. The full state word is exposed for test.

Top module: `lcg_noise_gen`

## Requirements
- R1: After a committed update, the state equals (previous state × 1664525 + 1013904223) mod 2^32.
- R2: The sample word presented with each valid pulse equals bits 31 down to 20 of the state held just before that update was committed.
- R3: A request is accepted on a rising edge where req_i is high, busy_o is low and load_i is low. The update commits exactly 3 rising edges later, and valid_o is high in the cycle after that edge.
- R4: valid_o is never high for two consecutive cycles.
- R5: busy_o is high from the edge that accepts a request until the committing edge. A request seen while busy_o is high is ignored: it causes no extra state change and no extra valid pulse.
- R6: On an edge with load_i high, the state takes seed_i, any in-flight update is cancelled without a valid pulse, and a request in the same cycle is ignored.
- R7: After synchronous reset, the state is 0, the sample word is 0, and valid_o and busy_o are low.
- R8: The state changes only on a load edge or on a committing edge.
- R9: From seed 0, the first three committed states are 0x3C6EF35F, 0x47502932 and 0xD1CCF6E9, and the samples presented with them are 0x000, 0x3C6 and 0x475.
- R10: While req_i is held high continuously, the block accepts a new request every 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seed_i | input | 32 | Seed value written by load_i |
| load_i | input | 1 | Seed write strobe; overrides requests |
| req_i | input | 1 | Sample request strobe |
| sample_o | output | 12 | Sample word, the top bits of the pre-update state |
| valid_o | output | 1 | One-cycle pulse marking a new sample word |
| busy_o | output | 1 | High while an update is in flight |
| state_o | output | 32 | Current recurrence state, for test |

## Verification
A fault in any partial-product row, in the row sum or in the add stage reaches state_o at the first commit after the request, 3 edges after acceptance. Because the recurrence feeds back, every later state and sample diverges from the model as well. A fault in the stage-valid chain shows as a valid pulse at the wrong cycle, a busy output that stays high or drops early, or a missing or doubled update when requests are held high. A fault in the sample selection shows on sample_o in the same cycle that valid_o pulses.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
   localparam int unsigned LCG_W      = 32;
   localparam logic [31:0] LCG_MULT   = 32'd1664525;
   localparam logic [31:0] LCG_INC    = 32'd1013904223;
   // register stages between acceptance and commit: rows, sum, add
   localparam int unsigned LCG_STAGES = 3;
   // edges from the accepting edge to the committing edge
   localparam int unsigned LCG_LAT    = LCG_STAGES;
endpackage

// File: rtl/lcg_pp_stage.sv
// Stage 1: one registered partial-product row per operand chunk, modulo 2^W
module lcg_pp_stage #(
   parameter int unsigned STATE_W = 32,
   parameter int unsigned CHUNK_W = 16,
   parameter logic [STATE_W-1:0] MULT_K = '0
) (
   input  logic                                       clk,
   input  logic                                       rst,
   input  logic [STATE_W-1:0]                         opnd_i,
   output logic [STATE_W/CHUNK_W-1:0][STATE_W-1:0]    rows_o
);
   localparam int unsigned NCH = STATE_W / CHUNK_W;

   logic [NCH-1:0][STATE_W-1:0] rows_d;

   generate
      if (NCH == 1) begin : g_single
         assign rows_d[0] = opnd_i * MULT_K;
      end else begin : g_split
         for (genvar i = 0; i < NCH; i++) begin : g_row
            logic [STATE_W-1:0] piece;
            logic [STATE_W-1:0] prod;
            assign piece = STATE_W'(opnd_i[i*CHUNK_W +: CHUNK_W]);
            assign prod  = piece * MULT_K;
            assign rows_d[i] = prod << (i * CHUNK_W);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) rows_o <= '0;
      else     rows_o <= rows_d;
   end
endmodule

// File: rtl/lcg_row_sum.sv
// Stage 2: registered sum of the partial-product rows
module lcg_row_sum #(
   parameter int unsigned STATE_W = 32,
   parameter int unsigned NROWS   = 2
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [NROWS-1:0][STATE_W-1:0]  rows_i,
   output logic [STATE_W-1:0]             prod_o
);
   logic [STATE_W-1:0] sum_d;

   generate
      if (NROWS == 1) begin : g_pass
         assign sum_d = rows_i[0];
      end else begin : g_tree
         always_comb begin
            sum_d = '0;
            for (int r = 0; r < NROWS; r++) sum_d = sum_d + rows_i[r];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prod_o <= '0;
      else     prod_o <= sum_d;
   end
endmodule

// File: rtl/lcg_add_stage.sv
// Stage 3: registered addition of the recurrence increment
module lcg_add_stage #(
   parameter int unsigned STATE_W = 32,
   parameter logic [STATE_W-1:0] INC_K = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STATE_W-1:0] prod_i,
   output logic [STATE_W-1:0] next_o
);
   always_ff @(posedge clk) begin
      if (rst) next_o <= '0;
      else     next_o <= prod_i + INC_K;
   end
endmodule

// File: rtl/lcg_ctrl.sv
// Tracks the one update in flight: acceptance, busy and commit
module lcg_ctrl #(
   parameter int unsigned STAGES = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic req_i,
   input  logic load_i,
   output logic busy_o,
   output logic commit_o
);
   logic [STAGES-1:0] stg_q;
   logic              accept;

   assign busy_o   = |stg_q;
   assign accept   = req_i & ~busy_o & ~load_i;
   assign commit_o = stg_q[STAGES-1] & ~load_i;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst || load_i) stg_q <= '0;
            else               stg_q <= accept;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst || load_i) stg_q <= '0;
            else               stg_q <= {stg_q[STAGES-2:0], accept};
         end
      end
   endgenerate
endmodule

// File: rtl/lcg_noise_gen.sv
module lcg_noise_gen #(
   parameter int unsigned STATE_W  = lcg_pkg::LCG_W,
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned CHUNK_W  = 16,
   parameter logic [STATE_W-1:0] MULT_K = STATE_W'(lcg_pkg::LCG_MULT),
   parameter logic [STATE_W-1:0] INC_K  = STATE_W'(lcg_pkg::LCG_INC),
   parameter logic [STATE_W-1:0] RST_SEED = '0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [STATE_W-1:0]  seed_i,
   input  logic                load_i,
   input  logic                req_i,
   output logic [SAMPLE_W-1:0] sample_o,
   output logic                valid_o,
   output logic                busy_o,
   output logic [STATE_W-1:0]  state_o
);
   localparam int unsigned NCH   = STATE_W / CHUNK_W;
   localparam int unsigned TOP_LO = STATE_W - SAMPLE_W;

   initial begin : p_param_chk
      assert (STATE_W % CHUNK_W == 0)
         else $error("chunk width must divide the state width");
      assert (SAMPLE_W >= 1 && SAMPLE_W <= STATE_W)
         else $error("sample width out of range");
   end

   logic [STATE_W-1:0]          state_q;
   logic [NCH-1:0][STATE_W-1:0] rows;
   logic [STATE_W-1:0]          prod;
   logic [STATE_W-1:0]          next_val;
   logic                        commit;
   logic [SAMPLE_W-1:0]         sample_q;
   logic                        valid_q;

   lcg_ctrl #(.STAGES(lcg_pkg::LCG_STAGES)) u_ctrl (
      .clk(clk), .rst(rst), .req_i(req_i), .load_i(load_i),
      .busy_o(busy_o), .commit_o(commit)
   );

   lcg_pp_stage #(.STATE_W(STATE_W), .CHUNK_W(CHUNK_W), .MULT_K(MULT_K)) u_pp (
      .clk(clk), .rst(rst), .opnd_i(state_q), .rows_o(rows)
   );

   lcg_row_sum #(.STATE_W(STATE_W), .NROWS(NCH)) u_sum (
      .clk(clk), .rst(rst), .rows_i(rows), .prod_o(prod)
   );

   lcg_add_stage #(.STATE_W(STATE_W), .INC_K(INC_K)) u_add (
      .clk(clk), .rst(rst), .prod_i(prod), .next_o(next_val)
   );

   always_ff @(posedge clk) begin
      if (rst)         state_q <= RST_SEED;
      else if (load_i) state_q <= seed_i;
      else if (commit) state_q <= next_val;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sample_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= commit;
         if (commit) sample_q <= state_q[STATE_W-1:TOP_LO];
      end
   end

   assign sample_o = sample_q;
   assign valid_o  = valid_q;
   assign state_o  = state_q;
endmodule

// File: rtl/lcg_noise_gen_chk.sv
module lcg_noise_gen_chk #(
   parameter int unsigned STATE_W  = 32,
   parameter int unsigned SAMPLE_W = 12,
   parameter logic [STATE_W-1:0] MULT_K = '0,
   parameter logic [STATE_W-1:0] INC_K  = '0,
   parameter logic [STATE_W-1:0] RST_SEED = '0
) (
   input logic                clk,
   input logic                rst,
   input logic [STATE_W-1:0]  seed_i,
   input logic                load_i,
   input logic                req_i,
   input logic [SAMPLE_W-1:0] sample_o,
   input logic                valid_o,
   input logic                busy_o,
   input logic [STATE_W-1:0]  state_o
);
   localparam int unsigned LAT = lcg_pkg::LCG_LAT;
   logic [3:0] age;
   logic       acc;

   assign acc = req_i & ~busy_o & ~load_i;

   always_ff @(posedge clk) begin
      if (rst || load_i)   age <= '0;
      else if (acc)        age <= 4'd1;
      else if (age == LAT) age <= '0;
      else if (age != 0)   age <= age + 4'd1;
   end

   AST_STEP_RECURRENCE: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> state_o == $past(state_o) * MULT_K + INC_K); // R1
   AST_SAMPLE_FROM_OLD: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> sample_o == $past(state_o[STATE_W-1:STATE_W-SAMPLE_W])); // R2
   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> $past(age) == LAT); // R3
   AST_COMMIT_DUE: assert property (@(posedge clk) disable iff (rst)
      ($past(age) == LAT && !$past(load_i)) |-> valid_o); // R3
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o); // R4
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      acc |=> busy_o); // R5
   AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> $past(busy_o)); // R5
   AST_SEED_LOADED: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (state_o == $past(seed_i) && !valid_o && !busy_o)); // R6
   AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_o == RST_SEED && !valid_o && !busy_o && sample_o == '0)); // R7
   AST_STATE_HELD: assert property (@(posedge clk) disable iff (rst)
      (!$past(load_i) && !$past(rst) && !valid_o) |-> $stable(state_o)); // R8
endmodule

bind lcg_noise_gen lcg_noise_gen_chk #(
   .STATE_W(STATE_W), .SAMPLE_W(SAMPLE_W),
   .MULT_K(MULT_K), .INC_K(INC_K), .RST_SEED(RST_SEED)
) u_chk (
   .clk(clk), .rst(rst), .seed_i(seed_i), .load_i(load_i), .req_i(req_i),
   .sample_o(sample_o), .valid_o(valid_o), .busy_o(busy_o), .state_o(state_o)
);

// File: tb/lcg_noise_gen_test.sv
module lcg_noise_gen_test;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] seed_i = '0;
   logic        load_i = 1'b0;
   logic        req_i = 1'b0;
   logic [11:0] sample_o;
   logic        valid_o;
   logic        busy_o;
   logic [31:0] state_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcg_noise_gen uut (
      .clk(clk), .rst(rst), .seed_i(seed_i), .load_i(load_i), .req_i(req_i),
      .sample_o(sample_o), .valid_o(valid_o), .busy_o(busy_o), .state_o(state_o)
   );

   function automatic logic [31:0] model_next(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   task automatic check(input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One request pulse, checking busy, latency, state and sample
   task automatic one_request(input string rq, input logic [31:0] exp_state,
                              input logic [11:0] exp_sample);
      req_i = 1'b1;
      tick(1);
      req_i = 1'b0;
      check("R5", "busy after accept", {31'd0, busy_o}, 32'd1);
      check("R3", "no early valid", {31'd0, valid_o}, 32'd0);
      tick(2);
      check("R3", "no valid before commit", {31'd0, valid_o}, 32'd0);
      check("R5", "busy until commit", {31'd0, busy_o}, 32'd1);
      tick(1);
      check("R3", "valid at commit", {31'd0, valid_o}, 32'd1);
      check("R5", "busy cleared", {31'd0, busy_o}, 32'd0);
      check(rq, "state", state_o, exp_state);
      check("R2", "sample", {20'd0, sample_o}, {20'd0, exp_sample});
      tick(1);
      check("R4", "valid single cycle", {31'd0, valid_o}, 32'd0);
   endtask

   task automatic load_seed(input logic [31:0] s);
      seed_i = s;
      load_i = 1'b1;
      tick(1);
      load_i = 1'b0;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      tick(3);
      rst = 1'b0;
      tick(1);
      check("R7", "reset state", state_o, 32'd0);
      check("R7", "reset sample", {20'd0, sample_o}, 32'd0);
      check("R7", "reset valid", {31'd0, valid_o}, 32'd0);
      check("R7", "reset busy", {31'd0, busy_o}, 32'd0);
   endtask

   task automatic t_golden;
      one_request("R9", 32'h3C6EF35F, 12'h000);
      check("R1", "model step 1", state_o, model_next(32'd0));
      one_request("R9", 32'h47502932, 12'h3C6);
      one_request("R9", 32'hD1CCF6E9, 12'h475);
      tick(5);
      check("R8", "state held while idle", state_o, 32'hD1CCF6E9);
   endtask

   task automatic t_seeded;
      logic [31:0] s = 32'hDEADBEEF;
      load_seed(s);
      check("R6", "seed loaded", state_o, s);
      for (int k = 0; k < 4; k++) begin
         logic [31:0] nx = model_next(s);
         one_request("R1", nx, s[31:20]);
         s = nx;
      end
   endtask

   task automatic t_busy_ignore;
      logic [31:0] s0 = state_o;
      int nvalid = 0;
      req_i = 1'b1;
      tick(3);        // accepted at first edge, ignored at the next two
      req_i = 1'b0;
      for (int k = 0; k < 8; k++) begin
         tick(1);
         if (valid_o) nvalid++;
      end
      check("R5", "one valid despite extra requests", nvalid, 32'd1);
      check("R5", "single update", state_o, model_next(s0));
   endtask

   task automatic t_load_priority;
      int nvalid = 0;
      seed_i = 32'h12345678;
      load_i = 1'b1;
      req_i  = 1'b1;
      tick(1);
      load_i = 1'b0;
      req_i  = 1'b0;
      check("R6", "load wins over request", state_o, 32'h12345678);
      check("R6", "request dropped, not busy", {31'd0, busy_o}, 32'd0);
      for (int k = 0; k < 6; k++) begin
         tick(1);
         if (valid_o) nvalid++;
      end
      check("R6", "no valid after load+req", nvalid, 32'd0);
      check("R8", "state unchanged", state_o, 32'h12345678);
   endtask

   task automatic t_load_cancel;
      int nvalid = 0;
      req_i = 1'b1;
      tick(1);
      req_i = 1'b0;
      tick(1);
      load_seed(32'h0BADF00D);
      check("R6", "seed during flight", state_o, 32'h0BADF00D);
      for (int k = 0; k < 6; k++) begin
         tick(1);
         if (valid_o) nvalid++;
      end
      check("R6", "cancelled update gives no valid", nvalid, 32'd0);
      check("R6", "cancelled update leaves seed", state_o, 32'h0BADF00D);
   endtask

   task automatic t_hold_high;
      logic [31:0] s = state_o;
      int nvalid = 0;
      int first_at = -1;
      req_i = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         tick(1);
         if (valid_o) begin
            nvalid++;
            if (first_at < 0) first_at = k;
         end
      end
      req_i = 1'b0;
      tick(6);
      check("R10", "valids in 12 cycles", nvalid, 32'd3);
      check("R3", "first valid position", first_at, 32'd4);
      check("R10", "three updates", state_o, model_next(model_next(model_next(s))));
   endtask

   initial begin : p_main
      t_reset();
      t_golden();
      t_seeded();
      t_busy_ignore();
      t_load_priority();
      t_load_cancel();
      t_hold_high();
      t_reset();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : p_watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R3 watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule